// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets a host on a two-wire serial bus read and write a bank of 8-bit configuration registers addressed by an 8-bit index. The bus clock and the open-drain data line are sampled in the much faster block clock. The data line is split into a sampled input and a pull-low enable. The block recognises start and stop conditions and answers only to a fixed 7-bit device address. It accepts a register index and then moves data bytes, stepping the index after every byte.

A write frame carries the device address with the direction bit clear, the register index, and any number of data bytes. Each data byte leaves the block as a one-cycle write on the register-file port. To read, the host first writes the index, then issues a repeated start with the direction bit set. The block returns successive registers, taken from a combinational read port, until the host declines a byte. The register file itself sits outside the block. It holds volatile contents that return to their defaults on reset.

Top module: `cfg_serial_slave`

## Requirements
- R1: A falling data line while the bus clock is high begins a new frame at the device-address byte, even partway through a byte. A rising data line while the clock is high ends the frame and leaves the data line released.
- R2: In the first byte, the upper seven bits are compared with 0x6A and the lowest bit selects the direction (0 write, 1 read). On a match the block holds the data line low for the whole high phase of the ninth bus clock.
- R3: On a device-address mismatch the block gives no acknowledge, issues no register write and never pulls the data line until the next start.
- R4: In a write frame the second byte loads the register index and is acknowledged.
- R5: Every later complete byte in a write frame produces exactly one single-cycle write pulse carrying that byte, followed by an acknowledge.
- R6: The register index steps by one after every byte written or read.
- R7: In a read, the register at the current index is sent most significant bit first. The block changes the data line only while the bus clock is low, so each bit is stable across the high phase.
- R8: A host acknowledge (data low in the ninth clock) after a read byte makes the block send the next register. A host refusal (data high) silences the block until the next start or stop.
- R9: The register index wraps from 0xFF to 0x00 for both writes and reads.
- R10: While reset is held, the data line is released and no write pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled serial bus clock |
| sdaIn | input | 1 | Sampled serial data line |
| sdaOe | output | 1 | When 1, the block pulls the data line low |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 8 | Register index for the write |
| regWrData | output | 8 | Data for the write |
| regRdAddr | output | 8 | Register index presented to the read port |
| regRdData | input | 8 | Combinational read data for regRdAddr |

## Verification
A bus edge reaches the control about three block clocks after it appears on the pins: two synchroniser flops and one edge register. The pull-low enable is registered after the control, so acknowledges and read bits are in place about four clocks after the falling bus clock, and the write pulse appears at the same point. The bench holds each quarter of a bus bit for ten block clocks. It samples the data line near the start and near the end of each high phase, so every value it compares is long settled. Write pulses are checked by order against a queue of expected index and data pairs rather than by exact cycle.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBit;   // shift the sampled data bit in, count it
    logic clrBit;    // restart the bit count
    logic loadAddr;  // received byte becomes the register index
    logic incAddr;   // step the register index
    logic wrStrobe;  // issue a register write of the received byte
    logic loadTx;    // capture read data for transmission
    logic shiftTx;   // advance to the next transmit bit
    logic ackDrive;  // pull the data line low as acknowledge
    logic txDrive;   // drive the current transmit bit
  } dpCtl_t;

endpackage

// File: rtl/cfg_slave_sync.sv
module cfg_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLevel  = sclPipe[STAGES-1];
  assign sdaLevel  = sdaPipe[STAGES-1];
  assign sclRise   = sclLevel & ~sclPrev;
  assign sclFall   = ~sclLevel & sclPrev;
  assign startSeen = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopSeen  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

endmodule

// File: rtl/cfg_slave_ctrl.sv
module cfg_slave_ctrl
  import cfg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sdaLevel,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          startSeen,
  input  logic          stopSeen,
  input  logic          byteDone,
  input  logic [DW-1:0] rxByte,
  output dpCtl_t        ctl
);

  busState_t state, nextState;
  logic      masterAck;
  logic      addrHit;

  assign addrHit = (rxByte[DW-1 -: 7] == DEV_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      masterAck <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_RD_ACK && sclRise) masterAck <= ~sdaLevel;
    end
  end

  always_comb begin
    ctl          = '0;
    nextState    = state;
    ctl.ackDrive = (state == ST_DEV_ACK) || (state == ST_REG_ACK) || (state == ST_WR_ACK);
    ctl.txDrive  = (state == ST_RD);
    if (startSeen) begin
      nextState  = ST_DEV;
      ctl.clrBit = 1'b1;
    end else if (stopSeen) begin
      nextState  = ST_IDLE;
      ctl.clrBit = 1'b1;
    end else begin
      unique case (state)
        ST_DEV, ST_REG, ST_WR: begin
          if (sclRise && !byteDone) begin
            ctl.takeBit = 1'b1;
          end else if (sclFall && byteDone) begin
            if (state == ST_DEV) begin
              nextState = addrHit ? ST_DEV_ACK : ST_SKIP;
            end else if (state == ST_REG) begin
              ctl.loadAddr = 1'b1;
              nextState    = ST_REG_ACK;
            end else begin
              ctl.wrStrobe = 1'b1;
              ctl.incAddr  = 1'b1;
              nextState    = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            ctl.clrBit = 1'b1;
            if (rxByte[0]) begin
              ctl.loadTx = 1'b1;
              nextState  = ST_RD;
            end else begin
              nextState = ST_REG;
            end
          end
        end
        ST_REG_ACK, ST_WR_ACK: begin
          if (sclFall) begin
            ctl.clrBit = 1'b1;
            nextState  = ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise && !byteDone) begin
            ctl.takeBit = 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              ctl.incAddr = 1'b1;
              nextState   = ST_RD_ACK;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclFall) begin
            ctl.clrBit = 1'b1;
            if (masterAck) begin
              ctl.loadTx = 1'b1;
              nextState  = ST_RD;
            end else begin
              nextState = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // a start always restarts address reception
  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> state == ST_DEV);

  // a stop always returns to idle
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> state == ST_IDLE);

  // an acknowledge only follows a complete byte
  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.ackDrive) |-> byteDone);

  // an unaddressed slave stays silent until start or stop
  a_r3_skip_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && !startSeen && !stopSeen) |=> state == ST_SKIP);

endmodule

// File: rtl/cfg_slave_dp.sv
module cfg_slave_dp
  import cfg_slave_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          sdaLevel,
  input  logic          sclLevel,
  input  logic [DW-1:0] regRdData,
  output logic [DW-1:0] rxByte,
  output logic          byteDone,
  output logic          sdaOe,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [DW-1:0] regWrData,
  output logic [AW-1:0] regRdAddr
);

  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] bitCnt;
  logic [DW-1:0] rxShift;
  logic [DW-1:0] txShift;
  logic [AW-1:0] addrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      addrCnt   <= '0;
      sdaOe     <= 1'b0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      if (ctl.clrBit) begin
        bitCnt <= '0;
      end else if (ctl.takeBit) begin
        bitCnt  <= bitCnt + CW'(1);
        rxShift <= {rxShift[DW-2:0], sdaLevel};
      end
      if (ctl.loadTx) begin
        txShift <= regRdData;
      end else if (ctl.shiftTx) begin
        txShift <= {txShift[DW-2:0], 1'b0};
      end
      if (ctl.loadAddr) begin
        addrCnt <= AW'(rxShift);
      end else if (ctl.incAddr) begin
        addrCnt <= addrCnt + AW'(1);
      end
      regWrEn <= ctl.wrStrobe;
      if (ctl.wrStrobe) begin
        regWrAddr <= addrCnt;
        regWrData <= rxShift;
      end
      sdaOe <= ctl.ackDrive | (ctl.txDrive & ~txShift[DW-1]);
    end
  end

  assign rxByte    = rxShift;
  assign byteDone  = (bitCnt == CW'(DW));
  assign regRdAddr = addrCnt;

  // each received byte yields a single-cycle write
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // the data line is only touched while the bus clock is low
  a_r7_change_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel);

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sdaOe,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [DW-1:0] regWrData,
  output logic [AW-1:0] regRdAddr,
  input  logic [DW-1:0] regRdData
);

  logic          sclLevel, sdaLevel, sclRise, sclFall, startSeen, stopSeen;
  logic          byteDone;
  logic [DW-1:0] rxByte;
  dpCtl_t        ctl;

  cfg_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen)
  );

  cfg_slave_ctrl #(.DEV_ADDR(DEV_ADDR), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteDone(byteDone), .rxByte(rxByte), .ctl(ctl)
  );

  cfg_slave_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLevel(sdaLevel),
    .sclLevel(sclLevel), .regRdData(regRdData), .rxByte(rxByte),
    .byteDone(byteDone), .sdaOe(sdaOe), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdAddr(regRdAddr)
  );

endmodule

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaLine;
  logic       sdaOe;
  logic       regWrEn;
  logic [7:0] regWrAddr, regWrData, regRdAddr, regRdData;

  logic [7:0] regMem [256];
  logic [7:0] expMem [256];
  logic [15:0] expQ [$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit oeSeen = 1'b0;

  always #10 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = regMem[regRdAddr];

  cfg_serial_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  always @(posedge clk) if (regWrEn) regMem[regWrAddr] <= regWrData;

  always @(negedge clk) if (sdaOe) oeSeen = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every write pulse must match the next expected pair
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3/R5 unexpected write", {regWrAddr, regWrData}, 0);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check({regWrAddr, regWrData} == e, "R5/R6 write addr,data", {regWrAddr, regWrData}, e);
      end
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input logic b, output logic s1, output logic s2);
    sdaM = b;
    waitQ();
    sclM = 1'b1;
    waitQ();
    s1 = sdaLine;
    waitQ();
    s2 = sdaLine;
    sclM = 1'b0;
    waitQ();
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s1, s2);
    bitCycle(1'b1, s1, s2);
    acked = (s1 == 1'b0) && (s2 == 1'b0);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b, output bit steady);
    logic s1, s2;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s1, s2);
      b[i] = s1;
      if (s1 !== s2) steady = 1'b0;
    end
    bitCycle(giveAck ? 1'b0 : 1'b1, s1, s2);
    sdaM = 1'b1;
  endtask

  task automatic writeFrame(input logic [7:0] idx, input logic [7:0] d [], input string tag);
    bit a;
    logic [7:0] cur;
    cur = idx;
    startCond();
    sendByte(8'hD4, a);
    check(a, {tag, " R2 device ack (write)"}, a, 1);
    sendByte(idx, a);
    check(a, {tag, " R4 index ack"}, a, 1);
    foreach (d[k]) begin
      expQ.push_back({cur, d[k]});
      expMem[cur] = d[k];
      sendByte(d[k], a);
      check(a, {tag, " R5 data ack"}, a, 1);
      cur = cur + 8'd1;
    end
    stopCond();
    check(sdaOe == 1'b0, {tag, " R1 released after stop"}, sdaOe, 0);
  endtask

  task automatic readFrame(input logic [7:0] idx, input int n, input string tag);
    bit a, st;
    logic [7:0] got;
    logic [7:0] cur;
    cur = idx;
    startCond();
    sendByte(8'hD4, a);
    check(a, {tag, " R2 device ack"}, a, 1);
    sendByte(idx, a);
    check(a, {tag, " R4 index ack"}, a, 1);
    startCond();
    sendByte(8'hD5, a);
    check(a, {tag, " R2 device ack (read)"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, got, st);
      check(got == expMem[cur], {tag, " R7/R6/R9 read data"}, got, expMem[cur]);
      check(st, {tag, " R7 bit stable in high phase"}, st, 1);
      cur = cur + 8'd1;
    end
    // R8: after the refusal the block must stay silent
    oeSeen = 1'b0;
    for (int k = 0; k < 9; k++) begin
      logic s1, s2;
      bitCycle(1'b1, s1, s2);
    end
    check(!oeSeen, {tag, " R8 silent after refusal"}, oeSeen, 0);
    stopCond();
  endtask

  initial begin
    bit a;
    logic s1, s2;
    repeat (10) @(negedge clk);
    check(sdaOe == 1'b0, "R10 data released in reset", sdaOe, 0);
    check(regWrEn == 1'b0, "R10 no write in reset", regWrEn, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    writeFrame(8'h10, '{8'h3C, 8'hA5, 8'h5A}, "wr10");
    readFrame(8'h10, 3, "rd10");
    readFrame(8'h11, 1, "rd11");

    // R3: wrong device address, then bytes that must not be written
    oeSeen = 1'b0;
    startCond();
    sendByte(8'hA0, a);
    check(!a, "R3 no ack on mismatch", a, 0);
    sendByte(8'h20, a);
    sendByte(8'h77, a);
    check(!oeSeen, "R3 never drives after mismatch", oeSeen, 0);
    stopCond();
    check(expQ.size() == 0, "R3 no write after mismatch", expQ.size(), 0);

    // R3: wrong address with read direction
    oeSeen = 1'b0;
    startCond();
    sendByte(8'hD7, a);
    for (int k = 0; k < 9; k++) bitCycle(1'b1, s1, s2);
    check(!oeSeen, "R3 no read output on mismatch", oeSeen, 0);
    stopCond();

    // R1: start partway through a byte, then a full wrapping write (R9)
    startCond();
    for (int k = 0; k < 3; k++) bitCycle(1'b1, s1, s2);
    writeFrame(8'hFE, '{8'h11, 8'h22, 8'h33}, "wrap");
    readFrame(8'hFF, 2, "rdwrap");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R5 all writes seen", expQ.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule